// File: doc/BRIEF.md
# Regularised 2x2 Velocity Solver

This block closes a gradient-based motion estimator. For every pixel it takes the three distinct entries of a symmetric 2x2 least-squares matrix, called `a` (top left), `c` (off diagonal) and `d` (bottom right), together with a two-entry right-hand vector (`bx`, `by`). All five are signed integers. The block returns the two velocity components of the solved system as 25-bit floating-point words. The regularising constant is assumed to have been added to the diagonal upstream, so a singular matrix can still occur and is flagged.

Each input is converted to float. Six single-cycle multipliers form the cross products, and three single-cycle subtractors form the determinant and both numerators. Each way holds two iterative restoring dividers, which produce one quotient bit per cycle. Several such ways are used in strict rotation, so a new pixel can be accepted every `21/NW` cycles on average, even though every divider is busy for 21 cycles. Every pixel has the same latency, so results come out in the order in which pixels were accepted.

Top module: `vel_solver2x2`

## Requirements
- R1: A float word holds the sign in bit 24, a biased exponent (bias 127) in bits 23:16 and a 16-bit fraction in bits 15:0, with a hidden leading one. Velocity 5 is encoded as 25'h0814000 and velocity -3 as 25'h1808000.
- R2: The block computes det = a*d - c*c. It outputs vx = (d*bx - c*by)/det and vy = (a*by - c*bx)/det. Each quotient is truncated toward zero to 17 significant bits. For integer inputs of magnitude up to 255, no precision is lost before the division.
- R3: When det is zero, both velocities are output as zero and out_invalid is high. Otherwise out_invalid is low.
- R4: Any zero result is the all-zero word: no sign bit and no fraction bits.
- R5: The result of a pixel accepted on clock edge E appears with out_valid high, for one cycle, after edge E+22.
- R6: Exactly one result is produced per accepted pixel, in acceptance order. Nothing is produced while in_valid is low.
- R7: Each accepted pixel reserves the next way of the rotation for 21 cycles, and in_ready is low while that way is reserved. With three ways and a continuous input stream, three pixels are taken on consecutive edges and the fourth exactly 21 edges after the first.
- R8: After reset, in_ready is high and both out_valid and out_invalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pixel is offered |
| in_ready | output | 1 | The pixel is taken on this edge if in_valid is high |
| in_a | input | IW | Matrix entry a (signed integer) |
| in_c | input | IW | Matrix entry c (signed integer) |
| in_d | input | IW | Matrix entry d (signed integer) |
| in_bx | input | IW | Vector entry bx (signed integer) |
| in_by | input | IW | Vector entry by (signed integer) |
| out_valid | output | 1 | Result valid for one cycle |
| out_invalid | output | 1 | Determinant was zero |
| out_vx | output | 1+EW+MW | Horizontal velocity, float |
| out_vy | output | 1+EW+MW | Vertical velocity, float |

## Verification
A full grid of `a`, `c` and `d` from -3 to 3, crossed with several vectors, covers the following cases:
- singular matrices;
- zero numerators;
- every sign combination;
- quotients that do and do not need the one-step renormalisation.

A pseudo-random set with entries up to 255 exercises wide alignment shifts in the subtractors and long, non-terminating quotients, where truncation is visible in every fraction bit. A directed burst, offered while all ways are idle, separates a correct rotation from one that reuses a way too early or stalls too long. Fixed encodings of 5 and -3 pin the field layout independently of the arithmetic model.

// File: rtl/vel_solver2x2.sv
module vel_solver2x2 #(
  parameter int IW = 24,
  parameter int EW = 8,
  parameter int MW = 16,
  parameter int NW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [IW-1:0] in_a,
  input  logic signed [IW-1:0] in_c,
  input  logic signed [IW-1:0] in_d,
  input  logic signed [IW-1:0] in_bx,
  input  logic signed [IW-1:0] in_by,
  output logic                 out_valid,
  output logic                 out_invalid,
  output logic [EW+MW:0]       out_vx,
  output logic [EW+MW:0]       out_vy
);
  localparam int FW      = 1 + EW + MW;
  localparam int SW      = MW + 1;
  localparam int QB      = SW + 1;
  localparam int DIV_CYC = QB + 3;
  localparam int LAT     = QB + 4;
  localparam int BIAS    = (1 << (EW - 1)) - 1;
  localparam int EMAX    = (1 << EW) - 2;
  localparam int XW      = EW + 3;
  localparam int WW      = (NW > 1) ? $clog2(NW) : 1;
  localparam int CW      = $clog2(DIV_CYC);
  localparam int DCW     = $clog2(QB + 1);

  typedef logic [FW-1:0] flt_t;

  function automatic flt_t fpack(input logic s, input logic signed [XW-1:0] e, input logic [MW-1:0] f);
    if (e <= 0) return '0;
    if (e > EMAX) return {s, EW'(EMAX), {MW{1'b1}}};
    return {s, e[EW-1:0], f};
  endfunction

  function automatic flt_t i2f(input logic signed [IW-1:0] x);
    logic [IW-1:0] m;
    logic [IW+SW-1:0] t;
    int p;
    m = x[IW-1] ? (~x + 1'b1) : x;
    if (m == '0) return '0;
    p = 0;
    for (int i = 0; i < IW; i++) if (m[i]) p = i;
    t = ({{SW{1'b0}}, m} << (SW - 1)) >> p;
    return fpack(x[IW-1], XW'(BIAS + p), t[MW-1:0]);
  endfunction

  function automatic flt_t fmul(input flt_t x, input flt_t y);
    logic [2*SW-1:0] p;
    logic signed [XW-1:0] e;
    logic s;
    if (x[FW-2:MW] == '0 || y[FW-2:MW] == '0) return '0;
    s = x[FW-1] ^ y[FW-1];
    p = {1'b1, x[MW-1:0]} * {1'b1, y[MW-1:0]};
    e = XW'(x[FW-2:MW]) + XW'(y[FW-2:MW]) - XW'(BIAS);
    if (p[2*SW-1]) return fpack(s, e + XW'(1), p[2*SW-2 -: MW]);
    return fpack(s, e, p[2*SW-3 -: MW]);
  endfunction

  function automatic flt_t fadd(input flt_t x, input flt_t y);
    flt_t l, sm;
    logic [EW-1:0] d;
    logic [SW-1:0] ml, ms;
    logic [SW:0] sum;
    logic signed [XW-1:0] e;
    int p;
    if (x[FW-2:MW] == '0) return (y[FW-2:MW] == '0) ? '0 : y;
    if (y[FW-2:MW] == '0) return x;
    if (x[FW-2:0] >= y[FW-2:0]) begin l = x; sm = y; end
    else begin l = y; sm = x; end
    d  = l[FW-2:MW] - sm[FW-2:MW];
    ml = {1'b1, l[MW-1:0]};
    ms = (d >= EW'(SW)) ? '0 : ({1'b1, sm[MW-1:0]} >> d);
    e  = XW'(l[FW-2:MW]);
    if (l[FW-1] == sm[FW-1]) begin
      sum = {1'b0, ml} + {1'b0, ms};
      if (sum[SW]) return fpack(l[FW-1], e + XW'(1), sum[SW-1:1]);
      return fpack(l[FW-1], e, sum[MW-1:0]);
    end
    sum = {1'b0, ml - ms};
    if (sum == '0) return '0;
    p = 0;
    for (int i = 0; i < SW; i++) if (sum[i]) p = i;
    sum = sum << (SW - 1 - p);
    return fpack(l[FW-1], e - XW'(SW - 1 - p), sum[MW-1:0]);
  endfunction

  function automatic flt_t fsub(input flt_t x, input flt_t y);
    return fadd(x, {~y[FW-1], y[FW-2:0]});
  endfunction

  function automatic flt_t dpack(input logic s, input logic signed [XW-1:0] e, input logic [QB-1:0] q, input logic z);
    if (z) return '0;
    if (q[QB-1]) return fpack(s, e, q[QB-2 -: MW]);
    return fpack(s, e - XW'(1), q[QB-3 -: MW]);
  endfunction

  logic [WW-1:0] ptr, s1_w, s2_w, s3_w, sel;
  logic [NW-1:0] wbusy, fin, rinv;
  logic          acc, s1_v, s2_v, s3_v;
  flt_t fa, fc, fd, fbx, fby;
  flt_t pad, pcc, pdbx, pcby, paby, pcbx;
  flt_t det, nx, ny;
  flt_t rvx [NW];
  flt_t rvy [NW];

  assign in_ready = !wbusy[ptr];
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0;
      s1_w <= '0; s2_w <= '0; s3_w <= '0;
      fa <= '0; fc <= '0; fd <= '0; fbx <= '0; fby <= '0;
      pad <= '0; pcc <= '0; pdbx <= '0; pcby <= '0; paby <= '0; pcbx <= '0;
      det <= '0; nx <= '0; ny <= '0;
    end else begin
      s1_v <= acc;
      s2_v <= s1_v;
      s3_v <= s2_v;
      if (acc) begin
        ptr  <= (ptr == WW'(NW - 1)) ? '0 : ptr + 1'b1;
        s1_w <= ptr;
        fa   <= i2f(in_a);
        fc   <= i2f(in_c);
        fd   <= i2f(in_d);
        fbx  <= i2f(in_bx);
        fby  <= i2f(in_by);
      end
      if (s1_v) begin
        s2_w <= s1_w;
        pad  <= fmul(fa, fd);
        pcc  <= fmul(fc, fc);
        pdbx <= fmul(fd, fbx);
        pcby <= fmul(fc, fby);
        paby <= fmul(fa, fby);
        pcbx <= fmul(fc, fbx);
      end
      if (s2_v) begin
        s3_w <= s2_w;
        det  <= fsub(pad, pcc);
        nx   <= fsub(pdbx, pcby);
        ny   <= fsub(paby, pcbx);
      end
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_way
    logic [CW-1:0]        rcnt;
    logic [DCW-1:0]       dcnt;
    logic [SW:0]          rx, ry;
    logic [SW-1:0]        den;
    logic [QB-1:0]        qx, qy;
    logic                 sx, sy, zx, zy, dz, fn, load;
    logic signed [XW-1:0] ex, ey;

    assign load = s3_v && (s3_w == WW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rcnt <= '0;
      else if (acc && ptr == WW'(w)) rcnt <= CW'(DIV_CYC - 1);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dcnt <= '0; fn <= 1'b0; den <= '0;
        rx <= '0; ry <= '0; qx <= '0; qy <= '0;
        sx <= 1'b0; sy <= 1'b0; zx <= 1'b0; zy <= 1'b0; dz <= 1'b0;
        ex <= '0; ey <= '0;
      end else if (load) begin
        dcnt <= DCW'(QB);
        fn   <= 1'b0;
        den  <= {1'b1, det[MW-1:0]};
        rx   <= {2'b01, nx[MW-1:0]};
        ry   <= {2'b01, ny[MW-1:0]};
        qx   <= '0;
        qy   <= '0;
        sx   <= nx[FW-1] ^ det[FW-1];
        sy   <= ny[FW-1] ^ det[FW-1];
        ex   <= XW'(nx[FW-2:MW]) - XW'(det[FW-2:MW]) + XW'(BIAS);
        ey   <= XW'(ny[FW-2:MW]) - XW'(det[FW-2:MW]) + XW'(BIAS);
        zx   <= (nx[FW-2:MW] == '0);
        zy   <= (ny[FW-2:MW] == '0);
        dz   <= (det[FW-2:MW] == '0);
      end else begin
        fn <= (dcnt == DCW'(1));
        if (dcnt != '0) begin
          dcnt <= dcnt - 1'b1;
          if (rx >= {1'b0, den}) begin
            qx <= {qx[QB-2:0], 1'b1};
            rx <= (rx - {1'b0, den}) << 1;
          end else begin
            qx <= {qx[QB-2:0], 1'b0};
            rx <= rx << 1;
          end
          if (ry >= {1'b0, den}) begin
            qy <= {qy[QB-2:0], 1'b1};
            ry <= (ry - {1'b0, den}) << 1;
          end else begin
            qy <= {qy[QB-2:0], 1'b0};
            ry <= ry << 1;
          end
        end
      end
    end

    assign wbusy[w] = (rcnt != '0);
    assign fin[w]   = fn;
    assign rinv[w]  = dz;
    assign rvx[w]   = dz ? '0 : dpack(sx, ex, qx, zx);
    assign rvy[w]   = dz ? '0 : dpack(sy, ey, qy, zy);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NW; i++) if (fin[i]) sel = WW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_invalid <= 1'b0; out_vx <= '0; out_vy <= '0;
    end else begin
      out_valid <= |fin;
      if (|fin) begin
        out_invalid <= rinv[sel];
        out_vx      <= rvx[sel];
        out_vy      <= rvy[sel];
      end
    end
  end
endmodule

// File: rtl/vel_solver2x2_chk.sv
module vel_solver2x2_chk #(
  parameter int NW      = 3,
  parameter int DIV_CYC = 21,
  parameter int LAT     = 22,
  parameter int FW      = 25,
  parameter int MW      = 16,
  parameter int WW      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [WW-1:0] ptr,
  input logic [NW-1:0] fin,
  input logic          out_valid,
  input logic          out_invalid,
  input logic [FW-1:0] out_vx,
  input logic [FW-1:0] out_vy
);
  localparam int TW = $clog2(DIV_CYC);
  logic [LAT:0]    sr;
  logic [TW-1:0]   tm [NW];
  logic            acc;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      for (int i = 0; i < NW; i++) tm[i] <= '0;
    end else begin
      sr <= {sr[LAT-1:0], acc};
      for (int i = 0; i < NW; i++)
        if (acc && ptr == WW'(i)) tm[i] <= TW'(DIV_CYC - 1);
        else if (tm[i] != '0) tm[i] <= tm[i] - 1'b1;
    end
  end

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_vx == '0 && out_vy == '0); // R3
  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_vx[FW-2:MW] == '0 && out_vy[FW-2:MW] == '0 |-> out_vx == '0 && out_vy == '0); // R4
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sr[LAT]); // R5
  AST_ONE_FINISHER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin)); // R6
  AST_WAY_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> tm[ptr] == '0); // R7
endmodule

bind vel_solver2x2 vel_solver2x2_chk #(
  .NW(NW), .DIV_CYC(DIV_CYC), .LAT(LAT), .FW(FW), .MW(MW), .WW(WW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ptr(ptr), .fin(fin), .out_valid(out_valid), .out_invalid(out_invalid),
  .out_vx(out_vx), .out_vy(out_vy)
);

// File: tb/tb_vel_solver2x2.sv
module tb_vel_solver2x2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid, out_invalid;
  logic signed [23:0] in_a = '0, in_c = '0, in_d = '0, in_bx = '0, in_by = '0;
  logic [24:0] out_vx, out_vy;

  always #5 clk = ~clk;

  vel_solver2x2 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_c(in_c), .in_d(in_d), .in_bx(in_bx), .in_by(in_by),
    .out_valid(out_valid), .out_invalid(out_invalid), .out_vx(out_vx), .out_vy(out_vy)
  );

  int errors = 0, checks = 0, cyc = 0, wr = 0, rd = 0;
  logic [24:0] e_vx [0:4095];
  logic [24:0] e_vy [0:4095];
  logic        e_inv [0:4095];
  int          acc_at [0:4095];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] fq(input longint num, input longint den);
    longint n, d, q, qr;
    int kr;
    logic s;
    if (den == 0 || num == 0) return '0;
    s = (num < 0) != (den < 0);
    n = (num < 0) ? -num : num;
    d = (den < 0) ? -den : den;
    kr = 0; qr = 0;
    for (int k = -40; k <= 40; k++) begin
      q = (k >= 0) ? ((n << k) / d) : (n / (d << (-k)));
      if (q >= 65536 && q < 131072) begin kr = k; qr = q; break; end
    end
    return {s, 8'(143 - kr), qr[15:0]};
  endfunction

  task automatic send(input int a, input int c, input int d, input int bx, input int by);
    longint dt, nx, ny;
    in_a = 24'(a); in_c = 24'(c); in_d = 24'(d); in_bx = 24'(bx); in_by = 24'(by);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    dt = longint'(a) * d - longint'(c) * c;
    nx = longint'(d) * bx - longint'(c) * by;
    ny = longint'(a) * by - longint'(c) * bx;
    acc_at[wr] = cyc + 1;
    e_inv[wr]  = (dt == 0);
    e_vx[wr]   = (dt == 0) ? '0 : fq(nx, dt);
    e_vy[wr]   = (dt == 0) ? '0 : fq(ny, dt);
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) chk(1'b0, "R6 unexpected result", 64'(rd), 64'(wr));
      else begin
        chk(out_vx == e_vx[rd], (e_vx[rd] == '0) ? "R4 vx" : "R2 vx", 64'(out_vx), 64'(e_vx[rd]));
        chk(out_vy == e_vy[rd], (e_vy[rd] == '0) ? "R4 vy" : "R2 vy", 64'(out_vy), 64'(e_vy[rd]));
        chk(out_invalid == e_inv[rd], "R3 invalid flag", 64'(out_invalid), 64'(e_inv[rd]));
        chk(cyc - acc_at[rd] == 22, "R5 latency", 64'(cyc - acc_at[rd]), 64'd22);
        rd++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int b, seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R8 valid after reset", 64'(out_valid), 64'd0);
    chk(out_invalid == 1'b0, "R8 invalid after reset", 64'(out_invalid), 64'd0);

    send(1, 0, 1, 5, -3);
    while (!out_valid) @(negedge clk);
    chk(out_vx == 25'h0814000, "R1 encoding of 5", 64'(out_vx), 64'h0814000);
    chk(out_vy == 25'h1808000, "R1 encoding of -3", 64'(out_vy), 64'h1808000);
    repeat (30) @(negedge clk);

    b = wr;
    send(2, 1, 3, 4, 5);
    send(-7, 2, 9, -11, 6);
    send(5, 5, 5, 1, 1);
    send(3, -1, 4, 0, 8);
    chk(acc_at[b+1] - acc_at[b] == 1, "R7 second issue", 64'(acc_at[b+1] - acc_at[b]), 64'd1);
    chk(acc_at[b+2] - acc_at[b] == 2, "R7 third issue", 64'(acc_at[b+2] - acc_at[b]), 64'd2);
    chk(acc_at[b+3] - acc_at[b] == 21, "R7 fourth issue", 64'(acc_at[b+3] - acc_at[b]), 64'd21);

    for (int a = -3; a <= 3; a++)
      for (int c = -3; c <= 3; c++)
        for (int d = -3; d <= 3; d++)
          for (int i = 0; i < 3; i++)
            for (int j = 0; j < 2; j++)
              send(a, c, d, (i == 0) ? -5 : (i == 1) ? 0 : 7, (j == 0) ? -2 : 3);

    seed = 12345;
    for (int n = 0; n < 200; n++) begin
      int v [5];
      for (int m = 0; m < 5; m++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        v[m] = ((seed >> 8) % 511) - 255;
      end
      send(v[0], v[1], v[2], v[3], v[4]);
    end

    repeat (60) @(negedge clk);
    chk(rd == wr, "R6 one result per accepted pixel", 64'(rd), 64'(wr));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule